// File: doc/BRIEF.md
# Standby Power Sequencer with Output Mute

This controller brings the converter's digital and analog sections into and out of a low-power standby state. It watches an asynchronous, active-low standby request and runs on the system clock, which is 256 times the sample rate. From the request it drives four things. The first is the enable for the analog front end. The second is the gate for the internal logic clock. The third is the enable for the serial interface pin drivers; while it is low, those pins float. The fourth is a pair of forcing signals that hold the serial data line and the overload flag low.

When standby is requested, the serial pins are released at once and the overload flag is forced low. The analog section and the logic clock stay on for a fixed power-down interval, then switch off. When the request is withdrawn, the analog section and the clock restart and a fixed wake interval runs. After that the serial pins are driven again, but the data line stays muted for a whole number of sample periods so that the decimation filters can settle. That number is longer when the high-pass filter is on. Once the mute window has passed, a data-valid status is raised.

The request may change at any moment, including during a sequence, and the controller always ends in a consistent state.

Top module: `sby_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, `analogEn`, `logicClkEn`, `serialPinEn` and `dataValid` are 0, and `sdoForceLow` and `ovldForceLow` are 1.
- R2: `standbyN` passes through a two-flop synchroniser. When it goes high with the controller in standby, `analogEn` and `logicClkEn` rise on the third rising clock edge after the change.
- R3: The wake phase lasts `UP_CYCLES` clocks with `serialPinEn` = 0. After it, `serialPinEn` goes to 1 while `sdoForceLow` stays 1. `serialPinEn` = 1 only ever occurs with `analogEn` = `logicClkEn` = 1.
- R4: With `hpfEnable` = 0 when the mute phase starts, the mute lasts `MUTE_SAMPLES_NOHPF` × `SAMPLE_CLKS` clocks.
- R5: With `hpfEnable` = 1 when the mute phase starts, the mute lasts `MUTE_SAMPLES_HPF` × `SAMPLE_CLKS` clocks.
- R6: `hpfEnable` is captured on entry to the mute phase. A change during the mute has no effect on its length.
- R7: When the mute expires, `dataValid` rises and `sdoForceLow` falls in the same cycle. `dataValid` = 1 never occurs together with `sdoForceLow` = 1.
- R8: When `standbyN` falls in normal operation, `serialPinEn` drops and `ovldForceLow` rises on the third clock edge. `analogEn` and `logicClkEn` stay 1 for `DOWN_CYCLES` further clocks and then fall. Whenever `serialPinEn` = 0, `ovldForceLow` = 1.
- R9: A standby request during the wake or mute phase aborts that phase and starts power-down at once.
- R10: If the request is withdrawn during power-down, power-down still completes. The controller then spends one cycle in standby and starts a full wake, so a pulse of a single clock still ends in normal operation with `dataValid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 × sample rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyN | input | 1 | Asynchronous standby request, low = standby |
| hpfEnable | input | 1 | High-pass filter selected; sets the mute length |
| analogEn | output | 1 | Enable for the analog front end |
| logicClkEn | output | 1 | Gate for the internal logic clock |
| serialPinEn | output | 1 | Drive enable for the serial pins (0 = high impedance) |
| sdoForceLow | output | 1 | Holds serial data low |
| ovldForceLow | output | 1 | Holds the overload flag low |
| dataValid | output | 1 | Mute window has expired; output data are valid |

## Verification
The checker tests, on every cycle, the ordering relations between the outputs. Pins are driven only while power and clock are on. The overload flag is forced whenever the pins float. Valid data never coincide with a muted data line. Power is removed only after the pins were released, and data validity rises only out of a muted state. Only the bench scenarios can show the latencies: the synchroniser delay, the wake and power-down lengths, and the filter-dependent mute windows. They also cover the capture of the filter select, aborts during wake and mute, a release during power-down, and the recovery after a one-cycle pulse.

// File: rtl/sby_pkg.sv
package sby_pkg;

  typedef enum logic [2:0] {
    ST_STANDBY  = 3'd0,
    ST_PWRDOWN  = 3'd1,
    ST_WAKE     = 3'd2,
    ST_MUTE     = 3'd3,
    ST_RUN      = 3'd4
  } seqStateT;

  // Strobes from control to the timing datapath
  typedef struct packed {
    logic clrCycle;   // restart the cycle counter
    logic countEn;    // advance the cycle counter
    logic muteMode;   // wrap cycle counter per sample, count samples
    logic loadMute;   // clear sample count and capture filter select
  } seqStrobeT;

  // Status returned by the datapath
  typedef struct packed {
    logic downDone;
    logic upDone;
    logic muteDone;
  } seqStatusT;

endpackage

// File: rtl/sby_sync.sv
module sby_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/sby_timer.sv
module sby_timer
  import sby_pkg::*;
#(
  parameter int DOWN_CYCLES        = 32,
  parameter int UP_CYCLES          = 256,
  parameter int SAMPLE_CLKS        = 256,
  parameter int MUTE_SAMPLES_NOHPF = 1024,
  parameter int MUTE_SAMPLES_HPF   = 12288
) (
  input  logic      clk,
  input  logic      rstN,
  input  seqStrobeT strobe,
  input  logic      hpfEnable,
  output seqStatusT status
);
  localparam int CYC_MAX = (DOWN_CYCLES > UP_CYCLES) ?
                           ((DOWN_CYCLES > SAMPLE_CLKS) ? DOWN_CYCLES : SAMPLE_CLKS) :
                           ((UP_CYCLES > SAMPLE_CLKS) ? UP_CYCLES : SAMPLE_CLKS);
  localparam int SMP_MAX = (MUTE_SAMPLES_NOHPF > MUTE_SAMPLES_HPF) ?
                           MUTE_SAMPLES_NOHPF : MUTE_SAMPLES_HPF;
  localparam int CYC_W = $clog2(CYC_MAX + 1);
  localparam int SMP_W = $clog2(SMP_MAX + 1);

  localparam logic [CYC_W-1:0] DOWN_LAST   = CYC_W'(DOWN_CYCLES - 1);
  localparam logic [CYC_W-1:0] UP_LAST     = CYC_W'(UP_CYCLES - 1);
  localparam logic [CYC_W-1:0] SAMPLE_LAST = CYC_W'(SAMPLE_CLKS - 1);
  localparam logic [SMP_W-1:0] NOHPF_LAST  = SMP_W'(MUTE_SAMPLES_NOHPF - 1);
  localparam logic [SMP_W-1:0] HPF_LAST    = SMP_W'(MUTE_SAMPLES_HPF - 1);

  logic [CYC_W-1:0] cycleCnt;
  logic [SMP_W-1:0] sampleCnt;
  logic             hpfHeld;
  logic             sampleTick;
  logic [SMP_W-1:0] sampleLast;

  assign sampleTick = (cycleCnt == SAMPLE_LAST);
  assign sampleLast = hpfHeld ? HPF_LAST : NOHPF_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.clrCycle) begin
      cycleCnt <= '0;
    end else if (strobe.countEn) begin
      if (strobe.muteMode && sampleTick) cycleCnt <= '0;
      else                               cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
      hpfHeld   <= 1'b0;
    end else if (strobe.loadMute) begin
      sampleCnt <= '0;
      hpfHeld   <= hpfEnable;
    end else if (strobe.muteMode && sampleTick) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  assign status.downDone = (cycleCnt == DOWN_LAST);
  assign status.upDone   = (cycleCnt == UP_LAST);
  assign status.muteDone = sampleTick && (sampleCnt == sampleLast);
endmodule

// File: rtl/sby_control.sv
module sby_control
  import sby_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      awakeReq,
  input  seqStatusT status,
  output seqStrobeT strobe,
  output logic      analogEn,
  output logic      logicClkEn,
  output logic      serialPinEn,
  output logic      sdoForceLow,
  output logic      ovldForceLow,
  output logic      dataValid
);
  seqStateT state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_STANDBY: if (awakeReq) nextState = ST_WAKE;
      ST_PWRDOWN: if (status.downDone) nextState = ST_STANDBY;
      ST_WAKE: begin
        if (!awakeReq)         nextState = ST_PWRDOWN;
        else if (status.upDone) nextState = ST_MUTE;
      end
      ST_MUTE: begin
        if (!awakeReq)           nextState = ST_PWRDOWN;
        else if (status.muteDone) nextState = ST_RUN;
      end
      ST_RUN: if (!awakeReq) nextState = ST_PWRDOWN;
      default: nextState = ST_PWRDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STANDBY;
    else       state <= nextState;
  end

  always_comb begin
    strobe.clrCycle = (nextState != state);
    strobe.countEn  = (state == ST_PWRDOWN) || (state == ST_WAKE) || (state == ST_MUTE);
    strobe.muteMode = (state == ST_MUTE);
    strobe.loadMute = (state != ST_MUTE) && (nextState == ST_MUTE);
  end

  always_comb begin
    analogEn     = (state != ST_STANDBY);
    logicClkEn   = (state != ST_STANDBY);
    serialPinEn  = (state == ST_MUTE) || (state == ST_RUN);
    sdoForceLow  = (state != ST_RUN);
    ovldForceLow = !((state == ST_MUTE) || (state == ST_RUN));
    dataValid    = (state == ST_RUN);
  end
endmodule

// File: rtl/sby_sequencer.sv
module sby_sequencer
  import sby_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter int DOWN_CYCLES        = 32,
  parameter int UP_CYCLES          = 256,
  parameter int SAMPLE_CLKS        = 256,
  parameter int MUTE_SAMPLES_NOHPF = 1024,
  parameter int MUTE_SAMPLES_HPF   = 12288
) (
  input  logic clk,
  input  logic rstN,
  input  logic standbyN,
  input  logic hpfEnable,
  output logic analogEn,
  output logic logicClkEn,
  output logic serialPinEn,
  output logic sdoForceLow,
  output logic ovldForceLow,
  output logic dataValid
);
  logic      awakeReq;
  seqStrobeT strobe;
  seqStatusT status;

  sby_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(standbyN), .syncOut(awakeReq)
  );

  sby_timer #(
    .DOWN_CYCLES(DOWN_CYCLES), .UP_CYCLES(UP_CYCLES), .SAMPLE_CLKS(SAMPLE_CLKS),
    .MUTE_SAMPLES_NOHPF(MUTE_SAMPLES_NOHPF), .MUTE_SAMPLES_HPF(MUTE_SAMPLES_HPF)
  ) uTimer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hpfEnable(hpfEnable), .status(status)
  );

  sby_control uCtrl (
    .clk(clk), .rstN(rstN), .awakeReq(awakeReq), .status(status), .strobe(strobe),
    .analogEn(analogEn), .logicClkEn(logicClkEn), .serialPinEn(serialPinEn),
    .sdoForceLow(sdoForceLow), .ovldForceLow(ovldForceLow), .dataValid(dataValid)
  );
endmodule

// File: rtl/sby_sequencer_checker.sv
module sby_sequencer_checker (
  input logic clk,
  input logic rstN,
  input logic analogEn,
  input logic logicClkEn,
  input logic serialPinEn,
  input logic sdoForceLow,
  input logic ovldForceLow,
  input logic dataValid
);
  // R3: pins are driven only with power and clock running
  p_pins_powered_r3: assert property (@(posedge clk) disable iff (!rstN)
    serialPinEn |-> (analogEn && logicClkEn));

  // R7: valid data never meet a muted data line
  p_valid_unmuted_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> !sdoForceLow);

  // R7: validity rises only from a muted state
  p_valid_after_mute_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(sdoForceLow && serialPinEn));

  // R8: floating pins imply a forced overload flag
  p_ovld_forced_r8: assert property (@(posedge clk) disable iff (!rstN)
    !serialPinEn |-> ovldForceLow);

  // R8: power goes away only after the pins were released
  p_power_after_pins_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(analogEn) |-> $past(!serialPinEn));
endmodule

bind sby_sequencer sby_sequencer_checker uChecker (
  .clk(clk), .rstN(rstN), .analogEn(analogEn), .logicClkEn(logicClkEn),
  .serialPinEn(serialPinEn), .sdoForceLow(sdoForceLow),
  .ovldForceLow(ovldForceLow), .dataValid(dataValid)
);

// File: tb/sby_sequencer_test.sv
`timescale 1ns/1ps
module sby_sequencer_test;
  localparam int DOWN  = 4;
  localparam int UP    = 8;
  localparam int SMP   = 4;
  localparam int NNO   = 3;
  localparam int NHPF  = 5;
  localparam int LIMIT = 500;
  localparam int SYNC  = 3;   // two sync flops plus state register

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyN = 1'b1;
  logic hpfEnable = 1'b0;
  logic analogEn, logicClkEn, serialPinEn, sdoForceLow, ovldForceLow, dataValid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sby_sequencer #(
    .SYNC_STAGES(2), .DOWN_CYCLES(DOWN), .UP_CYCLES(UP), .SAMPLE_CLKS(SMP),
    .MUTE_SAMPLES_NOHPF(NNO), .MUTE_SAMPLES_HPF(NHPF)
  ) uut (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .hpfEnable(hpfEnable),
    .analogEn(analogEn), .logicClkEn(logicClkEn), .serialPinEn(serialPinEn),
    .sdoForceLow(sdoForceLow), .ovldForceLow(ovldForceLow), .dataValid(dataValid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=200000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic sig(input int sel);
    case (sel)
      0: return analogEn;
      1: return serialPinEn;
      2: return dataValid;
      3: return ovldForceLow;
      default: return sdoForceLow;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // number of negedges until signal sel equals lvl (-1 on timeout)
  task automatic measure(input int sel, input logic lvl, output int n);
    n = -1;
    for (int i = 1; i <= LIMIT; i++) begin
      @(negedge clk);
      if (sig(sel) == lvl) begin
        n = i;
        return;
      end
    end
  endtask

  // Full wake from standby; returns after dataValid has risen
  task automatic wakeSweep(input logic hpf, input string req);
    int n1, n2, n3;
    int mute;
    hpfEnable = hpf;
    mute = (hpf ? NHPF : NNO) * SMP;
    standbyN = 1'b1;
    measure(0, 1'b1, n1);
    chk("R2 wake latency", n1, SYNC);
    chk("R2 clock gate with analog", logicClkEn, 1);
    measure(1, 1'b1, n2);
    chk("R3 wake length", n2, UP);
    chk("R3 sdo muted at pin enable", sdoForceLow, 1);
    measure(2, 1'b1, n3);
    chk(req, n3, mute);
    chk("R7 sdo released with valid", sdoForceLow, 0);
  endtask

  initial begin
    int n;
    // R1 reset state
    standbyN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 analogEn", analogEn, 0);
    chk("R1 serialPinEn", serialPinEn, 0);
    chk("R1 dataValid", dataValid, 0);
    chk("R1 forces", {sdoForceLow, ovldForceLow}, 2'b11);
    rstN = 1'b1;
    chk("R1 after release", {analogEn, logicClkEn, dataValid}, 0);

    // R2 R3 R4 wake with filter off
    wakeSweep(1'b0, "R4 mute length hpf off");

    // R8 power-down timing
    standbyN = 1'b0;
    measure(1, 1'b0, n);
    chk("R8 pins released", n, SYNC);
    chk("R8 ovld forced", ovldForceLow, 1);
    chk("R8 analog kept during power-down", analogEn, 1);
    measure(0, 1'b0, n);
    chk("R8 power-down length", n, DOWN);
    chk("R8 clock gated", logicClkEn, 0);

    // R5 wake with filter on
    wakeSweep(1'b1, "R5 mute length hpf on");

    // R6 filter change during mute is ignored
    standbyN = 1'b0;
    measure(0, 1'b0, n);
    hpfEnable = 1'b0;
    standbyN = 1'b1;
    measure(1, 1'b1, n);
    hpfEnable = 1'b1;
    measure(2, 1'b1, n);
    chk("R6 captured select", n, NNO * SMP);

    // R9 abort during mute
    standbyN = 1'b0;
    measure(0, 1'b0, n);
    hpfEnable = 1'b0;
    standbyN = 1'b1;
    measure(1, 1'b1, n);
    repeat (2) @(negedge clk);
    standbyN = 1'b0;
    measure(1, 1'b0, n);
    chk("R9 mute abort pins", n, SYNC);
    chk("R9 mute abort valid", dataValid, 0);
    measure(0, 1'b0, n);
    chk("R9 mute abort power-down", n, DOWN);

    // R9 abort during wake
    standbyN = 1'b1;
    measure(0, 1'b1, n);
    standbyN = 1'b0;
    measure(0, 1'b0, n);
    chk("R9 wake abort power-down", n, SYNC + DOWN);
    chk("R9 wake abort pins", serialPinEn, 0);

    // R10 release during power-down
    wakeSweep(1'b0, "R4 mute length repeat");
    standbyN = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
    standbyN = 1'b1;
    measure(0, 1'b0, n);
    chk("R10 power-down completes", n, DOWN - 2);
    measure(0, 1'b1, n);
    chk("R10 one standby cycle", n, 1);
    measure(2, 1'b1, n);
    chk("R10 full rewake", n, UP + NNO * SMP);

    // R10 single-cycle pulse
    standbyN = 1'b0;
    @(negedge clk);
    standbyN = 1'b1;
    measure(0, 1'b0, n);
    chk("R10 pulse power-down", n, SYNC + DOWN - 1);
    measure(2, 1'b1, n);
    chk("R10 pulse recovery", n, 1 + UP + NNO * SMP);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule